// File: doc/BRIEF.md
# Charge-Pulse Count and Code Assembler

This block is the per-channel digital back end of a self-regulating integrating front end. The analog integrator keeps itself inside its range by injecting charge steps. A step is triggered whenever its output crosses an upper or a lower comparison level, and each step is reported to this block on one of two asynchronous strobes. The integrator is never reset. Each integration period is therefore measured in two parts: a coarse part, which is the net number of steps times a calibrated step height, and a fine part, which is the difference between ADC samples of the integrator output taken at the end and at the start of the period.

The block synchronizes both strobes and counts their rising edges with opposite signs. At each period boundary it freezes the count and clears it. When the period's sample pair arrives, it combines the frozen count, the held step height and the sample difference into one saturated, signed 14-bit code with a single-cycle valid strobe. The step height is written through a load port. It stays in use across periods until it is reloaded.

Top module: `charge_code_assembler`

## Requirements
- R1: Each rising edge of `upStrobe` adds +1 to the running net count and each rising edge of `dnStrobe` adds -1. The strobes are asynchronous and each high level lasts at least two clock cycles.
- R2: With net count N, step height H (unsigned), start sample A and end sample B (both unsigned 8-bit), the delivered code is N*H + (B - A), saturated as R7 describes.
- R3: A one-cycle `periodEnd` pulse freezes the net count for the period that is closing and restarts counting from zero, so periods never share pulses.
- R4: A strobe edge that is detected on the same cycle as `periodEnd` is counted in the following period, not the closing one.
- R5: A period with no pulses delivers exactly B - A, including negative differences.
- R6: At least 100 pulses of one polarity in a single period are counted without wrap-around, in either direction.
- R7: The code is two's complement and clamps to the range -8192 to +8191 instead of wrapping.
- R8: A cycle with `heightLoad` high stores `heightIn` as the step height. That value is used for every later period until the next load.
- R9: `resultValid` is high for exactly the one cycle after each cycle with `samplesValid` high, and only then. `result` holds its value between valid pulses.
- R10: After reset, `result` is 0, `resultValid` is 0, the net count is 0 and the step height is 0.
- R11: Rising edges on both strobes detected in the same cycle leave the net count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| upStrobe | input | 1 | Asynchronous strobe for an upper-level step (+1) |
| dnStrobe | input | 1 | Asynchronous strobe for a lower-level step (-1) |
| periodEnd | input | 1 | One-cycle integration period boundary |
| heightLoad | input | 1 | Load enable for the step height |
| heightIn | input | 8 | Calibrated step height, unsigned |
| samplesValid | input | 1 | One-cycle qualifier for the sample pair |
| startSample | input | 8 | ADC sample at period start, unsigned |
| endSample | input | 8 | ADC sample at period end, unsigned |
| result | output | 14 | Saturated signed code |
| resultValid | output | 1 | One-cycle valid for `result` |

## Verification
The main function is driven with several kinds of period:
- Mixed up and down pulses with a rising sample pair. These show whether the two polarities are weighted with opposite signs.
- A pulse-free period with a falling sample pair. This isolates the fine subtraction and its sign.
- Runs of 100 pulses of one polarity, first at a small height and then at a large one. These separate counter overflow from correct clamping at either end of the range.
- Simultaneous strobes, and an edge placed on the boundary cycle. These show whether pulses cancel, and whether a boundary pulse lands in the correct period.

// File: rtl/cca_pkg.sv
package cca_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic incUp;        // synchronized rising edge, upper-level step
    logic incDn;        // synchronized rising edge, lower-level step
    logic closePeriod;  // freeze and restart the net count
    logic assemble;     // sample pair present: build the code
  } cca_strobes_t;

endpackage

// File: rtl/cca_pulse_sync.sv
module cca_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              lastLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain   <= '0;
      lastLvl <= 1'b0;
    end else begin
      chain   <= {chain[STAGES-2:0], asyncIn};
      lastLvl <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~lastLvl;

endmodule

// File: rtl/cca_control.sv
module cca_control
  import cca_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         upStrobe,
  input  logic         dnStrobe,
  input  logic         periodEnd,
  input  logic         samplesValid,
  output cca_strobes_t strobes
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] rawIn;
  logic [NUM_SRC-1:0] edgeSeen;

  assign rawIn = {dnStrobe, upStrobe};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    cca_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .asyncIn (rawIn[i]),
      .rise    (edgeSeen[i])
    );
  end

  always_comb begin
    strobes.incUp       = edgeSeen[0];
    strobes.incDn       = edgeSeen[1];
    strobes.closePeriod = periodEnd;
    strobes.assemble    = samplesValid;
  end

endmodule

// File: rtl/cca_datapath.sv
module cca_datapath
  import cca_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int HEIGHT_W = 8,
  parameter int CNT_W    = 8,
  parameter int RES_W    = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  cca_strobes_t        strobes,
  input  logic                heightLoad,
  input  logic [HEIGHT_W-1:0] heightIn,
  input  logic [SAMPLE_W-1:0] startSample,
  input  logic [SAMPLE_W-1:0] endSample,
  output logic [RES_W-1:0]    result,
  output logic                resultValid
);

  localparam int SUM_W = CNT_W + HEIGHT_W + SAMPLE_W + 2;
  localparam logic signed [SUM_W-1:0] RES_MAX = SUM_W'((2 ** (RES_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] RES_MIN = -SUM_W'(2 ** (RES_W - 1));

  logic signed [CNT_W-1:0]  liveCount;
  logic signed [CNT_W-1:0]  frozenCount;
  logic signed [CNT_W-1:0]  stepDelta;
  logic [HEIGHT_W-1:0]      heightReg;
  logic signed [SUM_W-1:0]  countExt;
  logic signed [SUM_W-1:0]  heightExt;
  logic signed [SUM_W-1:0]  coarse;
  logic signed [SUM_W-1:0]  endExt;
  logic signed [SUM_W-1:0]  startExt;
  logic signed [SUM_W-1:0]  total;
  logic [RES_W-1:0]         clamped;

  // Signed contribution of this cycle's edges
  always_comb begin
    unique case ({strobes.incUp, strobes.incDn})
      2'b10:   stepDelta = CNT_W'(1);
      2'b01:   stepDelta = -CNT_W'(1);
      default: stepDelta = '0;
    endcase
  end

  // Running count, frozen copy at the boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveCount   <= '0;
      frozenCount <= '0;
    end else if (strobes.closePeriod) begin
      frozenCount <= liveCount;
      liveCount   <= stepDelta;
    end else begin
      liveCount   <= liveCount + stepDelta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heightReg <= '0;
    end else if (heightLoad) begin
      heightReg <= heightIn;
    end
  end

  // Coarse plus fine, full width, then clamp
  always_comb begin
    countExt  = SUM_W'(frozenCount);
    heightExt = $signed({{(SUM_W-HEIGHT_W){1'b0}}, heightReg});
    endExt    = $signed({{(SUM_W-SAMPLE_W){1'b0}}, endSample});
    startExt  = $signed({{(SUM_W-SAMPLE_W){1'b0}}, startSample});
    coarse    = countExt * heightExt;
    total     = coarse + endExt - startExt;
    if (total > RES_MAX) begin
      clamped = RES_MAX[RES_W-1:0];
    end else if (total < RES_MIN) begin
      clamped = RES_MIN[RES_W-1:0];
    end else begin
      clamped = total[RES_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobes.assemble;
      if (strobes.assemble) begin
        result <= clamped;
      end
    end
  end

endmodule

// File: rtl/charge_code_assembler.sv
module charge_code_assembler
  import cca_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int HEIGHT_W    = 8,
  parameter int CNT_W       = 8,
  parameter int RES_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                upStrobe,
  input  logic                dnStrobe,
  input  logic                periodEnd,
  input  logic                heightLoad,
  input  logic [HEIGHT_W-1:0] heightIn,
  input  logic                samplesValid,
  input  logic [SAMPLE_W-1:0] startSample,
  input  logic [SAMPLE_W-1:0] endSample,
  output logic [RES_W-1:0]    result,
  output logic                resultValid
);

  cca_strobes_t strobes;

  cca_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .upStrobe     (upStrobe),
    .dnStrobe     (dnStrobe),
    .periodEnd    (periodEnd),
    .samplesValid (samplesValid),
    .strobes      (strobes)
  );

  cca_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .HEIGHT_W (HEIGHT_W),
    .CNT_W    (CNT_W),
    .RES_W    (RES_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .heightLoad  (heightLoad),
    .heightIn    (heightIn),
    .startSample (startSample),
    .endSample   (endSample),
    .result      (result),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/cca_checker.sv
module cca_checker #(
  parameter int RES_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             upStrobe,
  input logic             dnStrobe,
  input logic             samplesValid,
  input logic             resultValid,
  input logic [RES_W-1:0] result
);

  // R9: a sample pair always yields a valid on the next cycle
  a_r9_valid_after_samples: assert property (@(posedge clk) disable iff (!rstN)
    samplesValid |=> resultValid);

  // R9: no valid without a sample pair on the cycle before
  a_r9_valid_needs_samples: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(samplesValid));

  // R9: code holds between valid pulses
  a_r9_result_holds: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

  // R1: strobe high levels last at least two cycles
  a_r1_up_min_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upStrobe) |=> upStrobe);

  a_r1_dn_min_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dnStrobe) |=> dnStrobe);

endmodule

bind charge_code_assembler cca_checker #(.RES_W(RES_W)) u_chk (.*);

// File: tb/tb_charge_code_assembler.sv
`timescale 1ns/1ps
module tb_charge_code_assembler;

  typedef struct {
    int    val;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        upStrobe = 1'b0;
  logic        dnStrobe = 1'b0;
  logic        periodEnd = 1'b0;
  logic        heightLoad = 1'b0;
  logic [7:0]  heightIn = '0;
  logic        samplesValid = 1'b0;
  logic [7:0]  startSample = '0;
  logic [7:0]  endSample = '0;
  logic [13:0] result;
  logic        resultValid;

  int   total = 0;
  int   bad = 0;
  int   hCur = 0;
  int   carry = 0;
  exp_t sbQ[$];

  always #2 clk = ~clk;

  charge_code_assembler dut (
    .clk(clk), .rstN(rstN), .upStrobe(upStrobe), .dnStrobe(dnStrobe),
    .periodEnd(periodEnd), .heightLoad(heightLoad), .heightIn(heightIn),
    .samplesValid(samplesValid), .startSample(startSample),
    .endSample(endSample), .result(result), .resultValid(resultValid)
  );

  function automatic int sat14(int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  task automatic pulse(input bit up, input bit dn);
    @(negedge clk);
    upStrobe = up;
    dnStrobe = dn;
    repeat (3) @(negedge clk);
    upStrobe = 1'b0;
    dnStrobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic loadHeight(input int h);
    @(negedge clk);
    heightIn   = 8'(h);
    heightLoad = 1'b1;
    @(negedge clk);
    heightLoad = 1'b0;
    hCur = h;
  endtask

  task automatic closeAndSample(input int net, input int a, input int b,
                                input string req);
    exp_t e;
    @(negedge clk);
    periodEnd = 1'b1;
    @(negedge clk);
    periodEnd = 1'b0;
    repeat (2) @(negedge clk);
    startSample  = 8'(a);
    endSample    = 8'(b);
    samplesValid = 1'b1;
    e.val = sat14(net * hCur + b - a);
    e.req = req;
    sbQ.push_back(e);
    @(negedge clk);
    samplesValid = 1'b0;
  endtask

  // Driver: one period with given pulse counts; expected code pushed
  task automatic runPeriod(input int ups, input int dns, input int boths,
                           input int a, input int b, input string req);
    int net;
    net = ups - dns + carry;
    carry = 0;
    for (int i = 0; i < ups; i++) pulse(1'b1, 1'b0);
    for (int i = 0; i < dns; i++) pulse(1'b0, 1'b1);
    for (int i = 0; i < boths; i++) pulse(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    closeAndSample(net, a, b, req);
  endtask

  // R4: an up edge detected on the boundary cycle belongs to the next period
  task automatic runPeriodBoundaryEdge(input int ups, input int a, input int b);
    exp_t e;
    int   net;
    net = ups + carry;
    carry = 0;
    for (int i = 0; i < ups; i++) pulse(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    upStrobe = 1'b1;
    repeat (2) @(negedge clk);
    periodEnd = 1'b1;
    @(negedge clk);
    periodEnd = 1'b0;
    upStrobe  = 1'b0;
    repeat (3) @(negedge clk);
    startSample  = 8'(a);
    endSample    = 8'(b);
    samplesValid = 1'b1;
    e.val = sat14(net * hCur + b - a);
    e.req = "R4";
    sbQ.push_back(e);
    @(negedge clk);
    samplesValid = 1'b0;
    carry = 1;
  endtask

  // Monitor: compare each valid against the scoreboard; check valid timing
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && (samplesValid || resultValid)) begin
        total++;
        if (resultValid !== samplesValid) begin
          bad++;
          $display("FAIL R9 valid timing: actual resultValid=%0b expected=%0b",
                   resultValid, samplesValid);
        end
      end
      if (rstN && resultValid) begin
        total++;
        if (sbQ.size() == 0) begin
          bad++;
          $display("FAIL R9 unexpected result: actual=%0d expected none",
                   $signed(result));
        end else begin
          exp_t e;
          e = sbQ.pop_front();
          if (int'($signed(result)) != e.val) begin
            bad++;
            $display("FAIL %s result: actual=%0d expected=%0d",
                     e.req, $signed(result), e.val);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    total++;
    if (result !== 14'd0) begin
      bad++;
      $display("FAIL R10 result: actual=%0d expected=0", result);
    end
    total++;
    if (resultValid !== 1'b0) begin
      bad++;
      $display("FAIL R10 resultValid: actual=%0b expected=0", resultValid);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10: height and count start at zero -> pure difference
    runPeriod(2, 0, 0, 10, 40, "R10");

    loadHeight(20);
    runPeriod(3, 1, 0, 100, 130, "R1 R2");    // 2*20+30 = 70
    runPeriod(0, 0, 0, 200, 50, "R5");        // -150
    runPeriod(0, 5, 0, 10, 10, "R1 R3");      // -100
    runPeriod(1, 0, 3, 0, 0, "R11");          // 20
    runPeriod(100, 0, 0, 0, 255, "R6");       // 2255
    runPeriod(0, 100, 0, 255, 0, "R6");       // -2255

    loadHeight(200);
    runPeriod(100, 0, 0, 0, 0, "R7");         // clamp 8191
    runPeriod(0, 100, 0, 0, 0, "R7");         // clamp -8192

    loadHeight(10);
    runPeriodBoundaryEdge(2, 50, 50);         // 20
    runPeriod(0, 0, 0, 50, 50, "R4 R3");      // carry 1 -> 10

    loadHeight(7);
    runPeriod(1, 0, 0, 0, 0, "R8");           // 7
    runPeriod(2, 0, 0, 5, 5, "R8");           // 14, height retained

    repeat (10) @(negedge clk);
    total++;
    if (sbQ.size() != 0) begin
      bad++;
      $display("FAIL R9 missing results: actual=%0d pending expected=0",
               sbQ.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule